// File: doc/BRIEF.md
# Bit-Serial CRC-8 Checker

This block folds a serial data stream, one bit per strobe and least significant bit first, into an 8-bit remainder. The remainder uses the reflected form of the generator x^8 + x^5 + x^4 + 1 and starts from zero. The same block serves a sender and a receiver. After the payload bits have gone in, the remainder is the check byte to transmit. If the received check byte is then shifted in as well, a clean stream leaves a remainder of zero.

A synchronous clear zeroes the remainder and the bit tally before each new stream. A frame-kind select picks the expected stream length. The short kind covers a 7-byte identity code plus its check byte, 64 bits. The long kind covers an 8-byte data block plus its check byte, 72 bits. The match output goes high when the tally equals the selected length and the remainder is zero. Cutting bytes out of the stream, and deciding what to do after a mismatch, are left to the surrounding logic.

Top module: `crc8_serial_chk`

## Requirements
- R1: After reset the remainder is 0x00, the bit tally is zero, `zero_res` is 1 and `match` is 0.
- R2: On each clock edge with `bit_vld` high and `clr` low, the block forms `fb = bit_in XOR rem[0]`. The next remainder is `(rem >> 1) XOR (fb ? 0x8C : 0x00)`, and it is visible on `rem` in the following cycle.
- R3: Bytes are consumed bit 0 first. Feeding the bytes 02 1C B8 01 00 00 00 from zero leaves the remainder 0xA2.
- R4: `clr` zeroes the remainder and the tally on the next edge. When `bit_vld` is high in the same cycle, `clr` wins and the bit is discarded.
- R5: With both `clr` and `bit_vld` low, the remainder and the tally hold their values.
- R6: The tally counts accepted bits and saturates at its maximum value instead of wrapping. A long run of zero bits therefore never brings `match` back.
- R7: `zero_res` is 1 exactly when the remainder is 0x00.
- R8: `match` is 1 when the remainder is zero and the tally equals the selected length. With `frame_kind` = 0 the length is 64 bits; with `frame_kind` = 1 it is 72 bits.
- R9: A stream followed by its own check byte ends with remainder zero. If any single bit of the stream is flipped, the remainder ends nonzero and `match` stays 0.
- R10: `match` stays 0 while the tally differs from the selected length, even when the remainder is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of remainder and tally |
| bit_vld | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Serial data bit |
| frame_kind | input | 1 | 0 selects the 64-bit length, 1 the 72-bit length |
| rem | output | 8 | Current remainder |
| zero_res | output | 1 | Remainder is zero |
| match | output | 1 | Remainder zero at the selected length |

## Verification
The bench builds the block with its default parameters: lengths of 64 and 72 bits and a 7-bit tally that saturates at 127. With these values, a run of 192 zero bits goes past the point where an unsaturated tally would wrap back onto 64. The bench uses that run to show that saturation is what keeps `match` low. The default reflected constant lets a known 7-byte identity code and a known 8-byte data block be checked against their published check bytes, both with and without each check byte appended.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_e;
endpackage

// File: rtl/crc8_bit_step.sv
// One serial step of the reflected CRC: shift right, fold feedback in.
module crc8_bit_step #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'h8C
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    logic fb;
    assign fb = bit_in ^ crc_in[0];

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            assign crc_out[i] = fb & POLY[i];
        end else begin : g_mid
            assign crc_out[i] = crc_in[i+1] ^ (fb & POLY[i]);
        end
    end
endmodule

// File: rtl/crc8_bit_tally.sv
// Saturating count of accepted bits; clear has priority.
module crc8_bit_tally #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_TALLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R6
    AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/crc8_serial_chk.sv
module crc8_serial_chk
    import crc8_pkg::*;
#(
    parameter int               SHORT_BITS = 64,
    parameter int               LONG_BITS  = 72,
    parameter logic [CRC_W-1:0] POLY       = POLY_REFL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             frame_kind,
    output logic [CRC_W-1:0] rem,
    output logic             zero_res,
    output logic             match
);
    localparam int MAX_LEN = (LONG_BITS > SHORT_BITS) ? LONG_BITS : SHORT_BITS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_BITS);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_BITS);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } chk_st_t;

    chk_st_t          st_d, st_q;
    logic [CRC_W-1:0] crc_step;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_sel;

    crc8_bit_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .crc_in  (st_q.crc),
        .bit_in  (bit_in),
        .crc_out (crc_step)
    );

    crc8_bit_tally #(.CW(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (bit_vld),
        .cnt   (cnt_q)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.crc = '0;
        end else if (bit_vld) begin
            st_d.crc = crc_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len_sel  = (frame_e'(frame_kind) == FRAME_LONG) ? LEN_LONG : LEN_SHORT;
    assign rem      = st_q.crc;
    assign zero_res = (st_q.crc == '0);
    assign match    = zero_res && (cnt_q == len_sel);

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0 && cnt_q == '0)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !bit_vld) |=> ($stable(rem) && $stable(cnt_q))); // R5
    AST_FEEDBACK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bit_vld) |=> (rem[CRC_W-1] == ($past(bit_in) ^ $past(rem[0])) & POLY[CRC_W-1])); // R2
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bit_vld) |=> (rem[0] == ($past(rem[1]) ^ (($past(bit_in) ^ $past(rem[0])) & POLY[0])))); // R2
    AST_MATCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (cnt_q == LEN_SHORT || cnt_q == LEN_LONG)); // R10
endmodule

// File: tb/tb_crc8_serial_chk.sv
module tb_crc8_serial_chk;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       frame_kind = 1'b0;
    logic [7:0] rem;
    logic       zero_res;
    logic       match;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    crc8_serial_chk dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld),
        .bit_in(bit_in), .frame_kind(frame_kind),
        .rem(rem), .zero_res(zero_res), .match(match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_bit(input logic [7:0] c, input logic b);
        logic f;
        f = b ^ c[0];
        return (c >> 1) ^ (f ? 8'h8C : 8'h00);
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = model_bit(r, d[i]);
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "rem after reset", rem, 8'h00);
        check("R1", "zero_res after reset", zero_res, 1'b1);
        check("R1", "match after reset", match, 1'b0);
    endtask

    task automatic t_single_bits();
        logic [7:0] exp;
        do_clear();
        exp = 8'h00;
        send_bit(1'b1); exp = model_bit(exp, 1'b1);
        check("R2", "rem after one 1-bit", rem, 8'h8C);
        send_bit(1'b0); exp = model_bit(exp, 1'b0);
        check("R2", "rem after 1,0", rem, exp);
        send_bit(1'b1); exp = model_bit(exp, 1'b1);
        check("R2", "rem after 1,0,1", rem, exp);
        check("R7", "zero_res low on nonzero rem", zero_res, 1'b0);
    endtask

    task automatic t_rom_code();
        logic [7:0] rom [7] = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
        logic [7:0] exp;
        do_clear();
        frame_kind = 1'b0;
        exp = 8'h00;
        for (int k = 0; k < 7; k++) begin
            send_byte(rom[k]);
            exp = model_byte(exp, rom[k]);
        end
        check("R3", "ROM check byte", rem, 8'hA2);
        check("R3", "ROM model agrees", exp, 8'hA2);
        check("R10", "no match at 56 bits", match, 1'b0);
        send_byte(8'hA2);
        check("R9", "residue zero after check byte", rem, 8'h00);
        check("R7", "zero_res high at zero residue", zero_res, 1'b1);
        check("R8", "match at 64 bits short kind", match, 1'b1);
        frame_kind = 1'b1;
        #1;
        check("R8", "no match at 64 bits long kind", match, 1'b0);
        frame_kind = 1'b0;
    endtask

    task automatic t_scratch();
        logic [7:0] pad [8] = '{8'h50, 8'h05, 8'h4B, 8'h46, 8'h7F, 8'hFF, 8'h0C, 8'h10};
        logic [7:0] exp;
        do_clear();
        frame_kind = 1'b1;
        exp = 8'h00;
        for (int k = 0; k < 8; k++) begin
            send_byte(pad[k]);
            exp = model_byte(exp, pad[k]);
        end
        check("R3", "data block check byte", rem, exp);
        send_byte(exp);
        check("R9", "data block residue zero", rem, 8'h00);
        check("R8", "match at 72 bits long kind", match, 1'b1);
        send_bit(1'b0);
        check("R10", "match drops at 73 bits", match, 1'b0);
        frame_kind = 1'b0;
    endtask

    task automatic t_corrupt();
        logic [7:0] rom [7] = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
        do_clear();
        frame_kind = 1'b0;
        for (int k = 0; k < 7; k++) send_byte((k == 3) ? (rom[k] ^ 8'h10) : rom[k]);
        send_byte(8'hA2);
        check("R9", "corrupted stream residue nonzero", (rem != 8'h00), 1'b1);
        check("R9", "corrupted stream no match", match, 1'b0);
    endtask

    task automatic t_clr_priority();
        do_clear();
        send_byte(8'h5A);
        clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        check("R4", "clr beats strobe rem", rem, 8'h00);
        for (int i = 0; i < 64; i++) send_bit(1'b0);
        check("R4", "tally cleared: match at 64 zero bits", match, 1'b1);
    endtask

    task automatic t_hold();
        logic [7:0] snap;
        do_clear();
        send_byte(8'hC3);
        snap = rem;
        bit_in = 1'b1;
        repeat (5) @(negedge clk);
        bit_in = 1'b0;
        check("R5", "rem held without strobe", rem, snap);
        do_clear();
        for (int i = 0; i < 60; i++) send_bit(1'b0);
        repeat (10) @(negedge clk);
        check("R5", "tally held: no match at 60", match, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        check("R5", "tally held: match at 64", match, 1'b1);
    endtask

    task automatic t_saturate();
        do_clear();
        frame_kind = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        check("R10", "zero rem at 8 bits no match", match, 1'b0);
        check("R7", "zero_res with zero data", zero_res, 1'b1);
        for (int i = 8; i < 192; i++) send_bit(1'b0);
        check("R6", "no match after 192 zero bits", match, 1'b0);
        check("R6", "rem still zero", rem, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_rom_code();
        t_scratch();
        t_corrupt();
        t_clr_priority();
        t_hold();
        t_saturate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule